// File: doc/BRIEF.md
# Multi-Source Reset Controller with Power-Up Timer

This block merges every reset request on the chip into a single chip reset. The requests are a power-on pulse, an active-low external master-clear pin, a brown-out detect, a watchdog timeout, a reset-instruction strobe, and stack-full and stack-underflow events. A set/reset style register holds the chip reset. Any active request sets it. How it clears depends on the kind of request.

Supply-related requests are power-on and brown-out. After one of these goes away, a power-up timer keeps the chip in reset for 2048 ticks of a slow tick. The tick is derived from the system clock by a parameterised divider, and the default models a period of roughly 32 µs. All other requests release the chip as soon as they go away.

A status register records the cause of each reset in active-low sticky flags. Software reads this register and re-arms it through a plain write port. Writes are ignored while the chip is held in reset.

Top module: `rst_ctrl`

## Requirements
- R1: While `por_i` is high, `chip_rst_o` is set at the next clock edge and `flags_o` takes the value 7'h7C. In that value bit 0 (brown-out) and bit 1 (power-on) are 0, and bits 2 to 6 are 1.
- R2: After the last edge at which `por_i` or a brown-out is active, `chip_rst_o` stays high for exactly 2048*TICK_DIV further clock edges and falls at edge number 2048*TICK_DIV.
- R3: With BROWNOUT_EN=1, an active `bod_i` sets the chip reset, clears flag bit 0 only and starts the power-up timer. With BROWNOUT_EN=0, `bod_i` changes neither `chip_rst_o` nor `flags_o`.
- R4: `mclr_n_i` passes through a two-flop synchroniser. `chip_rst_o` rises at the third edge after the pin goes low and falls at the third edge after it goes high, with no timer wait. With `lowpower_i`=0, a master-clear leaves `flags_o` unchanged.
- R5: A master-clear while `lowpower_i`=1 clears flag bit 2.
- R6: A one-cycle `wdt_i` strobe raises `chip_rst_o` for exactly one cycle and clears flag bit 3.
- R7: A one-cycle `rst_instr_i` strobe raises `chip_rst_o` for one cycle and clears flag bit 4.
- R8: A `stk_full_i` strobe clears flag bit 5 and a `stk_under_i` strobe clears flag bit 6. Each also gives a one-cycle reset.
- R9: While `chip_rst_o` is low, `flag_we_i` loads `flag_wdata_i` into `flags_o` at the next edge. While `chip_rst_o` is high, the write is ignored. If a cause event arrives in the same cycle as a write, the event's bit is 0 after that edge.
- R10: A flag changes only through its own event, a software write or power-on. A later reset of another cause leaves earlier cleared flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on pulse, active high; also initialises the block |
| mclr_n_i | input | 1 | External master-clear pin, active low, asynchronous |
| lowpower_i | input | 1 | High while the chip is in a power-managed mode |
| bod_i | input | 1 | Brown-out detect, active high |
| wdt_i | input | 1 | Watchdog timeout strobe |
| rst_instr_i | input | 1 | Reset instruction strobe |
| stk_full_i | input | 1 | Stack full event strobe |
| stk_under_i | input | 1 | Stack underflow event strobe |
| flag_we_i | input | 1 | Software write enable for the cause flags |
| flag_wdata_i | input | 7 | Software write data for the cause flags |
| flags_o | output | 7 | Active-low sticky cause flags |
| chip_rst_o | output | 1 | Chip reset, active high |

## Verification
The hardest behaviour to reach from the ports is the exact edge at which the power-up timer releases the chip. At the real tick rate that edge lies hundreds of thousands of cycles away. The bench builds the block with a divider of 2 and counts edges from the last edge at which power-on or brown-out was active. It checks that reset is still high one edge before 4096 edges and low exactly at 4096. A software write issued inside that long hold window confirms that writes are ignored while reset is asserted. A second instance built without brown-out support runs on the same stimulus.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;

    localparam int NFLAG      = 7;
    localparam int PWRT_TICKS = 2048;

    // flag bit positions (active-low cause flags)
    localparam int F_BRN = 0;
    localparam int F_PWR = 1;
    localparam int F_SLP = 2;
    localparam int F_WDT = 3;
    localparam int F_INS = 4;
    localparam int F_SFL = 5;
    localparam int F_SUN = 6;

    typedef logic [NFLAG-1:0] flag_vec_t;

    // one bit per flag, same order as the flag vector (msb = bit 6)
    typedef struct packed {
        logic sunder;
        logic sfull;
        logic instr;
        logic wdt;
        logic mclr_lp;
        logic pwr;
        logic brown;
    } cause_t;

    function automatic flag_vec_t por_flags();
        flag_vec_t v;
        v        = '1;
        v[F_BRN] = 1'b0;
        v[F_PWR] = 1'b0;
        return v;
    endfunction

    function automatic cause_t build_cause(
        input logic brown,
        input logic mclr_act,
        input logic lowpower,
        input logic wdt,
        input logic instr,
        input logic sfull,
        input logic sunder
    );
        cause_t c;
        c.brown   = brown;
        c.pwr     = 1'b0;
        c.mclr_lp = mclr_act & lowpower;
        c.wdt     = wdt;
        c.instr   = instr;
        c.sfull   = sfull;
        c.sunder  = sunder;
        return c;
    endfunction

endpackage

// File: rtl/rst_ctrl_sync.sv
module rst_ctrl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-2:0], d_i};
    end

    assign q_o = sh[STAGES-1];
endmodule

// File: rtl/rst_ctrl_pwrt.sv
module rst_ctrl_pwrt #(
    parameter int TICK_DIV = 320,
    parameter int TICKS    = 2048
) (
    input  logic clk,
    input  logic por_i,
    input  logic restart_i,
    input  logic run_i,
    output logic expire_o
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int CW = $clog2(TICKS);
    localparam logic [PW-1:0] PLAST = PW'(TICK_DIV - 1);
    localparam logic [CW-1:0] CLAST = CW'(TICKS - 1);

    logic [PW-1:0] presc;
    logic [CW-1:0] cnt;
    logic          tick;

    assign tick     = (presc == PLAST);
    assign expire_o = run_i & tick & (cnt == CLAST);

    always_ff @(posedge clk) begin
        if (por_i || restart_i) begin
            presc <= '0;
            cnt   <= '0;
        end else if (run_i) begin
            if (tick) begin
                presc <= '0;
                cnt   <= cnt + CW'(1);
            end else begin
                presc <= presc + PW'(1);
            end
        end
    end

    // R2
    hold_while_idle_chk: assert property (@(posedge clk) disable iff (por_i)
        (!run_i && !restart_i) |=> $stable(cnt));
endmodule

// File: rtl/rst_ctrl_flags.sv
module rst_ctrl_flags
    import rst_ctrl_pkg::*;
(
    input  logic      clk,
    input  logic      por_i,
    input  logic      in_rst_i,
    input  logic      we_i,
    input  flag_vec_t wdata_i,
    input  cause_t    cause_i,
    output flag_vec_t flags_o
);
    flag_vec_t flags_q;
    flag_vec_t base;
    flag_vec_t ev;

    assign ev = flag_vec_t'(cause_i);

    always_comb begin
        base = flags_q;
        if (we_i && !in_rst_i) base = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (por_i) flags_q <= por_flags();
        else       flags_q <= base & ~ev;
    end

    assign flags_o = flags_q;

    // R9
    wr_ignored_chk: assert property (@(posedge clk) disable iff (por_i)
        (we_i && in_rst_i && (ev == '0)) |=> $stable(flags_q));

    // R8
    sun_clear_chk: assert property (@(posedge clk) disable iff (por_i)
        cause_i.sunder |=> !flags_q[F_SUN]);
endmodule

// File: rtl/rst_ctrl.sv
module rst_ctrl
    import rst_ctrl_pkg::*;
#(
    parameter int TICK_DIV    = 320,
    parameter int BROWNOUT_EN = 1
) (
    input  logic       clk,
    input  logic       por_i,
    input  logic       mclr_n_i,
    input  logic       lowpower_i,
    input  logic       bod_i,
    input  logic       wdt_i,
    input  logic       rst_instr_i,
    input  logic       stk_full_i,
    input  logic       stk_under_i,
    input  logic       flag_we_i,
    input  logic [6:0] flag_wdata_i,
    output logic [6:0] flags_o,
    output logic       chip_rst_o
);
    localparam logic BOD_KEEP = (BROWNOUT_EN != 0);

    logic   mclr_s;
    logic   mclr_act;
    logic   bod_eff;
    logic   src_any;
    logic   pend;
    logic   expire;
    logic   chip_rst_q;
    cause_t cause;

    rst_ctrl_sync #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst (por_i),
        .d_i (mclr_n_i),
        .q_o (mclr_s)
    );

    assign mclr_act = ~mclr_s;
    assign bod_eff  = bod_i & BOD_KEEP;
    assign src_any  = bod_eff | mclr_act | wdt_i | rst_instr_i | stk_full_i | stk_under_i;

    assign cause = build_cause(bod_eff, mclr_act, lowpower_i, wdt_i,
                               rst_instr_i, stk_full_i, stk_under_i);

    rst_ctrl_pwrt #(.TICK_DIV(TICK_DIV), .TICKS(PWRT_TICKS)) u_pwrt (
        .clk       (clk),
        .por_i     (por_i),
        .restart_i (bod_eff),
        .run_i     (pend & ~src_any),
        .expire_o  (expire)
    );

    // set/reset hold: sources set it, timer or source removal clears it
    always_ff @(posedge clk) begin
        if (por_i) begin
            chip_rst_q <= 1'b1;
            pend       <= 1'b1;
        end else begin
            if (bod_eff)     pend <= 1'b1;
            else if (expire) pend <= 1'b0;

            if (src_any)               chip_rst_q <= 1'b1;
            else if (!pend || expire)  chip_rst_q <= 1'b0;
        end
    end

    rst_ctrl_flags u_flags (
        .clk      (clk),
        .por_i    (por_i),
        .in_rst_i (chip_rst_q),
        .we_i     (flag_we_i),
        .wdata_i  (flag_wdata_i),
        .cause_i  (cause),
        .flags_o  (flags_o)
    );

    assign chip_rst_o = chip_rst_q;

    // R6
    src_set_chk: assert property (@(posedge clk) disable iff (por_i)
        src_any |=> chip_rst_o);

    // R2
    pend_hold_chk: assert property (@(posedge clk) disable iff (por_i)
        (pend && !expire) |=> chip_rst_o);

    // R4
    quick_release_chk: assert property (@(posedge clk) disable iff (por_i)
        (chip_rst_o && !pend && !src_any) |=> !chip_rst_o);
endmodule

// File: tb/sim_rst_ctrl.sv
module sim_rst_ctrl;
    logic       clk = 1'b0;
    logic       por = 1'b0, mclr_n = 1'b1, lowpower = 1'b0, bod = 1'b0;
    logic       wdt = 1'b0, instr = 1'b0, sfull = 1'b0, sunder = 1'b0;
    logic       we = 1'b0;
    logic [6:0] wdata = '0;
    logic [6:0] flags0, flags1;
    logic       rst0, rst1;
    int         checks = 0, failures = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    rst_ctrl #(.TICK_DIV(2), .BROWNOUT_EN(1)) u0 (
        .clk(clk), .por_i(por), .mclr_n_i(mclr_n), .lowpower_i(lowpower),
        .bod_i(bod), .wdt_i(wdt), .rst_instr_i(instr), .stk_full_i(sfull),
        .stk_under_i(sunder), .flag_we_i(we), .flag_wdata_i(wdata),
        .flags_o(flags0), .chip_rst_o(rst0));

    rst_ctrl #(.TICK_DIV(2), .BROWNOUT_EN(0)) u1 (
        .clk(clk), .por_i(por), .mclr_n_i(mclr_n), .lowpower_i(lowpower),
        .bod_i(bod), .wdt_i(wdt), .rst_instr_i(instr), .stk_full_i(sfull),
        .stk_under_i(sunder), .flag_we_i(we), .flag_wdata_i(wdata),
        .flags_o(flags1), .chip_rst_o(rst1));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] v);
        @(negedge clk); we = 1'b1; wdata = v;
        @(posedge clk);
        @(negedge clk); we = 1'b0;
    endtask

    // release after a supply source: expect 4096 edges with TICK_DIV=2
    task automatic wait_pwrt(input string tag);
        repeat (4094) @(posedge clk);
        @(negedge clk);
        chk({tag, " hold at 4095"}, rst0, 1);
        @(posedge clk); @(negedge clk);
        chk({tag, " release at 4096"}, rst0, 0);
    endtask

    task automatic t_por();
        @(negedge clk); por = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 chip_rst", rst0, 1);
        chk("R1 flags", flags0, 7'h7C);
        chk("R1 flags u1", flags1, 7'h7C);
        por = 1'b0; we = 1'b1; wdata = 7'h7F;   // write during hold
        @(posedge clk); @(negedge clk); we = 1'b0;
        chk("R9 write ignored in reset", flags0, 7'h7C);
        wait_pwrt("R2 por");
        chk("R2 u1 released", rst1, 0);
    endtask

    task automatic t_bod();
        wr(7'h7F);
        @(negedge clk); bod = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R3 bod reset", rst0, 1);
        chk("R3 bod flag", flags0, 7'h7E);
        chk("R3 disabled no reset", rst1, 0);
        chk("R3 disabled flags", flags1, 7'h7F);
        bod = 1'b0;
        @(posedge clk); @(negedge clk);
        wait_pwrt("R2 bod");
    endtask

    task automatic t_mclr(input logic lp);
        wr(7'h7F);
        @(negedge clk); mclr_n = 1'b0; lowpower = lp;
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R4 sync delay", rst0, 0);
        @(posedge clk); @(negedge clk);
        chk("R4 mclr reset", rst0, 1);
        if (lp) chk("R5 lowpower flag", flags0, 7'h7B);
        else    chk("R4 flags unchanged", flags0, 7'h7F);
        mclr_n = 1'b1;
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R4 release delay", rst0, 1);
        @(posedge clk); @(negedge clk);
        chk("R4 no timer wait", rst0, 0);
        lowpower = 1'b0;
    endtask

    task automatic t_wdt_instr();
        wr(7'h7F);
        @(negedge clk); wdt = 1'b1;
        @(posedge clk); @(negedge clk); wdt = 1'b0;
        chk("R6 wdt reset", rst0, 1);
        chk("R6 wdt flag", flags0, 7'h77);
        @(posedge clk); @(negedge clk);
        chk("R6 one cycle", rst0, 0);
        @(negedge clk); instr = 1'b1;
        @(posedge clk); @(negedge clk); instr = 1'b0;
        chk("R7 instr reset", rst0, 1);
        chk("R7 R10 flags sticky", flags0, 7'h67);
        @(posedge clk); @(negedge clk);
        chk("R7 release", rst0, 0);
    endtask

    task automatic t_stack();
        wr(7'h7F);
        @(negedge clk); sfull = 1'b1;
        @(posedge clk); @(negedge clk); sfull = 1'b0;
        chk("R8 full reset", rst0, 1);
        chk("R8 full flag", flags0, 7'h5F);
        @(posedge clk); @(negedge clk); sunder = 1'b1;
        @(posedge clk); @(negedge clk); sunder = 1'b0;
        chk("R8 under flag", flags0, 7'h1F);
        @(posedge clk); @(negedge clk);
        chk("R8 release", rst0, 0);
    endtask

    task automatic t_write();
        wr(7'h55);
        chk("R9 write lands", flags0, 7'h55);
        chk("R10 no reset from write", rst0, 0);
        @(negedge clk); we = 1'b1; wdata = 7'h7F; wdt = 1'b1;
        @(posedge clk); @(negedge clk); we = 1'b0; wdt = 1'b0;
        chk("R9 event beats write", flags0, 7'h77);
        @(posedge clk); @(negedge clk);
        chk("R9 release", rst0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_por();
        t_bod();
        t_mclr(1'b0);
        t_mclr(1'b1);
        t_wdt_instr();
        t_stack();
        t_write();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule